// File: doc/BRIEF.md
# Silicon Strip Cleanup and Cluster Finder

This block takes raw silicon strip amplitudes one strip per cycle. Each strip carries a chip number and a strip number. The block first cleans each strip. A strip flagged as bad is zeroed. Every strip then has the pedestal of its chip removed and is scaled by the gain of its chip. Bad-strip flags, pedestals, gains and the cluster threshold are all loaded through a small write-only register port.

Once the last strip of a chip has arrived, the block scans the stored corrected amplitudes of that chip and forms clusters. A cluster is a run of neighbouring strips whose amplitude is above threshold. For each cluster the block emits three things: the chip number, the summed charge of the cluster, and a sub-strip position. The position is an amplitude-weighted centroid over five strips centred on the cluster's brightest strip, given to one sixteenth of a strip. The centroid is produced by a bit-serial divider.

While the block is scanning and dividing, it holds its strip input not ready. Upstream logic therefore delivers one chip at a time.

Top module: `strip_clu_top`

## Requirements
- R1: A strip whose bad flag is set (register select 0, address {chip, strip}, data bit 0) contributes zero amplitude, whatever raw value it carries. Such a strip therefore never belongs to a cluster and adds nothing to any sum.
- R2: The corrected amplitude is floor(max(0, raw - pedestal[chip]) * gain[chip] / 64). The pedestal uses register select 1, the gain uses register select 2, and each is addressed by the chip number in the upper address bits. The gain is unsigned with 6 fractional bits.
- R3: A strip is a cluster member only when its corrected amplitude is strictly greater than the threshold (register select 3). Adjacent members form one cluster.
- R4: A cluster ends at the first non-member strip or after strip 127 of the chip. Clusters never span two chips, and each output carries the chip it came from.
- R5: The peak of a cluster is its highest corrected strip. When two strips tie, the lower strip index is the peak.
- R6: The reported centroid is floor(16 * sum(i * a_i) / sum(a_i)). The sum runs over strips peak-2 through peak+2, using corrected amplitudes, and any strip index outside 0..127 contributes zero. Bits [10:4] of the result hold the integer strip and bits [3:0] hold the fraction.
- R7: The reported charge is the sum of the corrected amplitudes of the cluster's member strips only.
- R8: Each cluster produces exactly one single-cycle outValid pulse, and clusters come out in ascending strip order.
- R9: After reset, inReady is high and outValid is low. inReady falls after strip 127 is accepted and stays low through every cluster output. It rises again once the scan of that chip has finished.
- R10: After reset, no strip is flagged bad, every pedestal is 0, every gain is 1.0 (64) and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 bad flag, 1 pedestal, 2 gain, 3 threshold |
| cfgAddr | input | 9 | {chip, strip} for bad flags; chip in bits [8:7] for tables |
| cfgData | input | 12 | Write data |
| inValid | input | 1 | Strip input valid |
| inReady | output | 1 | Block can accept a strip |
| inChip | input | 2 | Chip number of the strip |
| inStrip | input | 7 | Strip number within the chip |
| inAmp | input | 10 | Raw amplitude |
| outValid | output | 1 | Cluster result valid (one cycle) |
| outChip | output | 2 | Chip of the cluster |
| outCentroid | output | 11 | Centroid, 7 integer and 4 fractional bits |
| outCharge | output | 19 | Summed corrected charge of the cluster |

## Verification
The bench targets clusters touching strip 0 and strip 127. There, a design that wrapped the five-strip window or let a cluster run into the next chip would report a shifted centroid or an extra cluster. It also drives a strip exactly at threshold and a tie between two peak strips. An off-by-one comparison in either case moves the cluster boundary or the window centre.

A bad strip is placed both alone and inside a bump. The isolated case must yield no cluster, and the embedded case must split the bump into two clusters. Strips below pedestal check the clamp, because a missing clamp would make wrapped, huge amplitudes appear. Random frames across chips with distinct pedestals and gains expose any mixing of one chip's calibration into another's.

// File: rtl/strip_clu_pkg.sv
package strip_clu_pkg;

  localparam logic [1:0] SEL_BAD  = 2'd0;
  localparam logic [1:0] SEL_PED  = 2'd1;
  localparam logic [1:0] SEL_GAIN = 2'd2;
  localparam logic [1:0] SEL_THR  = 2'd3;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic writeStrip;
    logic clusterStart;
    logic clusterExtend;
    logic loadDiv;
    logic divStep;
  } ctlStrobes_t;

endpackage

// File: rtl/strip_clu_dp.sv
module strip_clu_dp
  import strip_clu_pkg::*;
#(
  parameter int N_CHIPS   = 4,
  parameter int STRIPS    = 128,
  parameter int AMP_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int FRAC_W    = 4
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       cfgWe,
  input  logic [1:0]                                 cfgSel,
  input  logic [$clog2(N_CHIPS)+$clog2(STRIPS)-1:0]  cfgAddr,
  input  logic [AMP_W+GAIN_W-GAIN_FRAC-1:0]          cfgData,
  input  logic [$clog2(N_CHIPS)-1:0]                 inChip,
  input  logic [$clog2(STRIPS)-1:0]                  inStrip,
  input  logic [AMP_W-1:0]                           inAmp,
  input  logic [$clog2(STRIPS):0]                    scanIdx,
  input  ctlStrobes_t                                strobes,
  output logic                                       above,
  output logic [$clog2(N_CHIPS)-1:0]                 curChip,
  output logic [$clog2(STRIPS)+FRAC_W-1:0]           quotient,
  output logic [AMP_W+GAIN_W-GAIN_FRAC+$clog2(STRIPS)-1:0] charge
);

  localparam int CHIP_W = $clog2(N_CHIPS);
  localparam int STRIP_W = $clog2(STRIPS);
  localparam int ADDR_W = CHIP_W + STRIP_W;
  localparam int CAL_W = AMP_W + GAIN_W - GAIN_FRAC;
  localparam int PROD_W = AMP_W + GAIN_W;
  localparam int QW = STRIP_W + FRAC_W;
  localparam int DEN_W = CAL_W + 3;
  localparam int NS_W = STRIP_W + CAL_W + 3;
  localparam int NUM_W = NS_W + FRAC_W;
  localparam int DIVR_W = DEN_W + QW - 1;
  localparam int CMP_W = (NUM_W > DIVR_W) ? NUM_W : DIVR_W;
  localparam int CHG_W = CAL_W + STRIP_W;
  localparam int PW = STRIP_W + 2;

  // configuration state
  logic [N_CHIPS*STRIPS-1:0] badMask;
  logic [AMP_W-1:0] pedTab [N_CHIPS];
  logic [GAIN_W-1:0] gainTab [N_CHIPS];
  logic [CAL_W-1:0] thrReg;
  logic [CHIP_W-1:0] tabChip;

  assign tabChip = cfgAddr[ADDR_W-1:STRIP_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badMask <= '0;
      thrReg  <= '0;
      for (int c = 0; c < N_CHIPS; c++) begin
        pedTab[c]  <= '0;
        gainTab[c] <= GAIN_W'(1) << GAIN_FRAC;
      end
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_BAD:  badMask[cfgAddr] <= cfgData[0];
        SEL_PED:  pedTab[tabChip] <= cfgData[AMP_W-1:0];
        SEL_GAIN: gainTab[tabChip] <= cfgData[GAIN_W-1:0];
        default:  thrReg <= cfgData;
      endcase
    end
  end

  // calibration of the incoming strip
  logic [AMP_W-1:0] rawEff;
  logic [AMP_W:0] diff;
  logic [AMP_W-1:0] posAmp;
  logic [PROD_W-1:0] prod;
  logic [CAL_W-1:0] calAmp;

  always_comb begin
    rawEff = badMask[{inChip, inStrip}] ? '0 : inAmp;
    diff   = {1'b0, rawEff} - {1'b0, pedTab[inChip]};
    posAmp = diff[AMP_W] ? '0 : diff[AMP_W-1:0];
    prod   = PROD_W'(posAmp) * PROD_W'(gainTab[inChip]);
    calAmp = prod[PROD_W-1:GAIN_FRAC];
  end

  // one chip worth of corrected amplitudes
  logic [CAL_W-1:0] stripStore [STRIPS];

  always_ff @(posedge clk) begin
    if (strobes.writeStrip) stripStore[inStrip] <= calAmp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curChip <= '0;
    else if (strobes.writeStrip) curChip <= inChip;
  end

  // scan port: index STRIPS is a virtual empty strip closing the chip
  logic [CAL_W-1:0] scanAmp;
  assign scanAmp = scanIdx[STRIP_W] ? '0 : stripStore[scanIdx[STRIP_W-1:0]];
  assign above = scanAmp > thrReg;

  // cluster peak and charge tracking
  logic [STRIP_W-1:0] peakIdx;
  logic [CAL_W-1:0] peakAmp;
  logic [CHG_W-1:0] chargeAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakIdx   <= '0;
      peakAmp   <= '0;
      chargeAcc <= '0;
    end else if (strobes.clusterStart) begin
      peakIdx   <= scanIdx[STRIP_W-1:0];
      peakAmp   <= scanAmp;
      chargeAcc <= CHG_W'(scanAmp);
    end else if (strobes.clusterExtend) begin
      chargeAcc <= chargeAcc + CHG_W'(scanAmp);
      if (scanAmp > peakAmp) begin
        peakIdx <= scanIdx[STRIP_W-1:0];
        peakAmp <= scanAmp;
      end
    end
  end

  // five-strip window sums around the peak
  logic [NS_W-1:0] numSum;
  logic [DEN_W-1:0] denSum;
  logic [PW-1:0] winPos [5];

  always_comb begin
    numSum = '0;
    denSum = '0;
    for (int k = 0; k < 5; k++) begin
      winPos[k] = {2'b00, peakIdx} + PW'(k) - PW'(2);
      if (winPos[k] < PW'(STRIPS)) begin
        numSum = numSum + NS_W'(winPos[k][STRIP_W-1:0]) *
                          NS_W'(stripStore[winPos[k][STRIP_W-1:0]]);
        denSum = denSum + DEN_W'(stripStore[winPos[k][STRIP_W-1:0]]);
      end
    end
  end

  // restoring divider, one quotient bit per step, msb first
  logic [NUM_W-1:0] remReg;
  logic [DIVR_W-1:0] divReg;
  logic [QW-1:0] quotReg;
  logic [CMP_W-1:0] remX, divX;
  logic geStep;

  assign remX = CMP_W'(remReg);
  assign divX = CMP_W'(divReg);
  assign geStep = remX >= divX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      divReg  <= '0;
      quotReg <= '0;
    end else if (strobes.loadDiv) begin
      remReg  <= {numSum, {FRAC_W{1'b0}}};
      divReg  <= {denSum, {(QW-1){1'b0}}};
      quotReg <= '0;
    end else if (strobes.divStep) begin
      if (geStep) remReg <= remReg - NUM_W'(divX);
      divReg  <= divReg >> 1;
      quotReg <= {quotReg[QW-2:0], geStep};
    end
  end

  assign quotient = quotReg;
  assign charge = chargeAcc;

endmodule

// File: rtl/strip_clu_ctrl.sv
module strip_clu_ctrl
  import strip_clu_pkg::*;
#(
  parameter int STRIPS = 128,
  parameter int FRAC_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [$clog2(STRIPS)-1:0] inStrip,
  input  logic                      above,
  output logic                      inReady,
  output logic                      outValid,
  output logic [$clog2(STRIPS):0]   scanIdx,
  output ctlStrobes_t               strobes
);

  localparam int STRIP_W = $clog2(STRIPS);
  localparam int QW = STRIP_W + FRAC_W;
  localparam int STEP_W = $clog2(QW);

  typedef enum logic [1:0] {ST_LOAD, ST_SCAN, ST_DIV, ST_EMIT} phase_t;

  phase_t phase;
  logic inClu;
  logic [STEP_W-1:0] stepCnt;
  logic lastIdx;

  assign lastIdx = scanIdx == (STRIP_W+1)'(STRIPS);
  assign inReady = phase == ST_LOAD;
  assign outValid = phase == ST_EMIT;

  always_comb begin
    strobes = '0;
    case (phase)
      ST_LOAD: strobes.writeStrip = inValid;
      ST_SCAN: begin
        strobes.clusterStart  = above && !inClu;
        strobes.clusterExtend = above && inClu;
        strobes.loadDiv       = !above && inClu;
      end
      ST_DIV:  strobes.divStep = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_LOAD;
      inClu   <= 1'b0;
      scanIdx <= '0;
      stepCnt <= '0;
    end else begin
      case (phase)
        ST_LOAD: begin
          if (inValid && inStrip == STRIP_W'(STRIPS - 1)) begin
            phase   <= ST_SCAN;
            scanIdx <= '0;
            inClu   <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (inClu && !above) begin
            phase   <= ST_DIV;
            stepCnt <= '0;
            inClu   <= 1'b0;
          end else begin
            inClu <= above;
            if (lastIdx) phase <= ST_LOAD;
            else scanIdx <= scanIdx + 1'b1;
          end
        end
        ST_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_W'(QW - 1)) phase <= ST_EMIT;
        end
        default: begin
          if (lastIdx) begin
            phase <= ST_LOAD;
          end else begin
            phase   <= ST_SCAN;
            scanIdx <= scanIdx + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/strip_clu_top.sv
module strip_clu_top
  import strip_clu_pkg::*;
#(
  parameter int N_CHIPS   = 4,
  parameter int STRIPS    = 128,
  parameter int AMP_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int FRAC_W    = 4,
  localparam int CHIP_W   = $clog2(N_CHIPS),
  localparam int STRIP_W  = $clog2(STRIPS),
  localparam int CAL_W    = AMP_W + GAIN_W - GAIN_FRAC,
  localparam int QW       = STRIP_W + FRAC_W,
  localparam int CHG_W    = CAL_W + STRIP_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgSel,
  input  logic [CHIP_W+STRIP_W-1:0] cfgAddr,
  input  logic [CAL_W-1:0]          cfgData,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [CHIP_W-1:0]         inChip,
  input  logic [STRIP_W-1:0]        inStrip,
  input  logic [AMP_W-1:0]          inAmp,
  output logic                      outValid,
  output logic [CHIP_W-1:0]         outChip,
  output logic [QW-1:0]             outCentroid,
  output logic [CHG_W-1:0]          outCharge
);

  ctlStrobes_t strobes;
  logic above;
  logic [STRIP_W:0] scanIdx;

  strip_clu_ctrl #(.STRIPS(STRIPS), .FRAC_W(FRAC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStrip(inStrip),
    .above(above), .inReady(inReady), .outValid(outValid),
    .scanIdx(scanIdx), .strobes(strobes)
  );

  strip_clu_dp #(
    .N_CHIPS(N_CHIPS), .STRIPS(STRIPS), .AMP_W(AMP_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .inChip(inChip),
    .inStrip(inStrip), .inAmp(inAmp), .scanIdx(scanIdx),
    .strobes(strobes), .above(above), .curChip(outChip),
    .quotient(outCentroid), .charge(outCharge)
  );

endmodule

// File: rtl/strip_clu_chk.sv
module strip_clu_chk #(
  parameter int STRIPS = 128,
  parameter int CHG_W  = 19
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic                      inReady,
  input logic [$clog2(STRIPS)-1:0] inStrip,
  input logic                      outValid,
  input logic [CHG_W-1:0]          outCharge
);

  // R9
  emit_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R9
  last_strip_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inStrip == $clog2(STRIPS)'(STRIPS - 1)) |=> !inReady);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7
  charge_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outCharge != '0);

endmodule

bind strip_clu_top strip_clu_chk #(.STRIPS(STRIPS), .CHG_W(CHG_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inStrip(inStrip), .outValid(outValid), .outCharge(outCharge)
);

// File: tb/strip_clu_top_test.sv
module strip_clu_top_test;

  localparam int NCH = 4;
  localparam int NS = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [8:0] cfgAddr = '0;
  logic [11:0] cfgData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inChip = '0;
  logic [6:0] inStrip = '0;
  logic [9:0] inAmp = '0;
  logic outValid;
  logic [1:0] outChip;
  logic [10:0] outCentroid;
  logic [18:0] outCharge;

  always #5 clk = ~clk;

  strip_clu_top uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .inValid(inValid),
    .inReady(inReady), .inChip(inChip), .inStrip(inStrip),
    .inAmp(inAmp), .outValid(outValid), .outChip(outChip),
    .outCentroid(outCentroid), .outCharge(outCharge)
  );

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // bench model of configuration
  int pedM [NCH];
  int gainM [NCH];
  int thrM;
  bit badM [NCH][NS];
  int raw [NS];
  int cal [NS];

  int expChip [$];
  int expCen [$];
  int expChg [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // output monitor, ordered comparison (R8)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expChip.size() == 0) begin
        check(1'b0, "R8", "unexpected cluster at centroid", outCentroid, -1);
      end else begin
        int eChip, eCen, eChg;
        eChip = expChip.pop_front();
        eCen = expCen.pop_front();
        eChg = expChg.pop_front();
        check(outChip == eChip, "R4", "cluster chip", outChip, eChip);
        check(outCentroid == eCen, "R6", "centroid", outCentroid, eCen);
        check(outCharge == eChg, "R7", "charge", outCharge, eChg);
      end
    end
  end

  task automatic cfgWrite(input int sel, input int addr, input int data);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgSel = 2'(sel);
    cfgAddr = 9'(addr);
    cfgData = 12'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setPed(input int c, input int v);
    pedM[c] = v;
    cfgWrite(1, c * NS, v);
  endtask

  task automatic setGain(input int c, input int v);
    gainM[c] = v;
    cfgWrite(2, c * NS, v);
  endtask

  task automatic setThr(input int v);
    thrM = v;
    cfgWrite(3, 0, v);
  endtask

  task automatic setBad(input int c, input int s, input bit v);
    badM[c][s] = v;
    cfgWrite(0, c * NS + s, int'(v));
  endtask

  // expected clusters from the requirement formulas
  task automatic predict(input int c);
    bit inC;
    int pk, pv, chg;
    inC = 0; pk = 0; pv = 0; chg = 0;
    for (int s = 0; s < NS; s++) begin
      int d;
      d = badM[c][s] ? 0 - pedM[c] : raw[s] - pedM[c];
      if (d < 0) d = 0;
      cal[s] = (d * gainM[c]) / 64;
    end
    for (int s = 0; s <= NS; s++) begin
      int a;
      a = (s < NS) ? cal[s] : 0;
      if (a > thrM) begin
        if (!inC) begin pk = s; pv = a; chg = a; end
        else begin
          chg += a;
          if (a > pv) begin pk = s; pv = a; end
        end
        inC = 1;
      end else if (inC) begin
        longint num, den;
        num = 0; den = 0;
        for (int p = pk - 2; p <= pk + 2; p++) begin
          if (p >= 0 && p < NS) begin
            num += longint'(p) * cal[p];
            den += cal[p];
          end
        end
        expChip.push_back(c);
        expCen.push_back(int'((num * 16) / den));
        expChg.push_back(chg);
        inC = 0;
      end
    end
  endtask

  task automatic sendFrame(input int c, input string req);
    predict(c);
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inChip = 2'(c);
      inStrip = 7'(s);
      inAmp = 10'(raw[s]);
    end
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R9", "ready after last strip", inReady, 0);
    while (!inReady) @(negedge clk);
    check(expChip.size() == 0, req, "clusters not seen", expChip.size(), 0);
    expChip.delete(); expCen.delete(); expChg.delete();
  endtask

  task automatic flat(input int c);
    for (int s = 0; s < NS; s++) raw[s] = pedM[c];
  endtask

  task automatic bump(input int c, input int s, input int v);
    raw[s] = pedM[c] + v;
  endtask

  task automatic randomFrame(input int c);
    int nh;
    for (int s = 0; s < NS; s++) begin
      int v;
      v = pedM[c] + int'($urandom_range(6, 0)) - 3;
      raw[s] = v < 0 ? 0 : v;
    end
    nh = int'($urandom_range(6, 0));
    for (int h = 0; h < nh; h++) begin
      int st, w;
      st = int'($urandom_range(NS - 1, 0));
      w = int'($urandom_range(6, 1));
      for (int s = st; s < st + w && s < NS; s++) begin
        int v;
        v = pedM[c] + int'($urandom_range(300, 0));
        raw[s] = v > 1023 ? 1023 : v;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      pedM[c] = 0; gainM[c] = 64;
      for (int s = 0; s < NS; s++) badM[c][s] = 0;
    end
    thrM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R9", "ready after reset", inReady, 1);
    check(outValid == 1'b0, "R9", "valid after reset", outValid, 0);

    // reset defaults: threshold 0, unit gain, no pedestal
    for (int s = 0; s < NS; s++) raw[s] = 0;
    raw[5] = 3; raw[6] = 9; raw[90] = 1; raw[127] = 40;
    sendFrame(0, "R10");

    setThr(20);
    setPed(0, 50); setGain(0, 64);
    setPed(1, 60); setGain(1, 96);
    setPed(2, 70); setGain(2, 40);
    setPed(3, 40); setGain(3, 200);

    flat(0);
    sendFrame(0, "R3");

    flat(0);
    bump(0, 0, 100); bump(0, 1, 40);
    bump(0, 126, 30); bump(0, 127, 90);
    sendFrame(0, "R4");

    flat(0);
    bump(0, 60, 25); bump(0, 62, 20); bump(0, 63, 19);
    sendFrame(0, "R3");

    flat(0);
    bump(0, 40, 50); bump(0, 41, 80); bump(0, 42, 80);
    bump(0, 43, 30); bump(0, 44, 25);
    bump(0, 70, 30); bump(0, 71, 5); bump(0, 72, 30);
    sendFrame(0, "R5");

    setBad(1, 10, 1'b1);
    setBad(1, 50, 1'b1);
    flat(1);
    raw[10] = 1023;
    for (int s = 48; s <= 52; s++) bump(1, s, 40);
    sendFrame(1, "R1");

    flat(2);
    for (int s = 0; s < NS; s += 3) raw[s] = pedM[2] - 30;
    for (int s = 20; s <= 24; s++) bump(2, s, 60 + 10 * s);
    sendFrame(2, "R2");

    for (int n = 0; n < 6; n++) setBad(3, int'($urandom_range(NS - 1, 0)), 1'b1);
    for (int f = 0; f < 24; f++) begin
      randomFrame(f % NCH);
      sendFrame(f % NCH, "R2");
    end

    setGain(3, 23); setPed(3, 5); setThr(7);
    setBad(1, 10, 1'b0);
    for (int f = 0; f < 8; f++) begin
      randomFrame(f % NCH);
      sendFrame(f % NCH, "R10");
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule